// File: doc/BRIEF.md
# Backup Oscillator Loss Monitor

This block watches the slow backup oscillator, the one that also clocks the watchdog, and reports when it has stopped. It runs entirely in the system clock domain. A counter advances once per system clock while the monitor waits for the backup clock to change level. Each level change it sees, rising or falling, sends the counter back to zero. If the counter reaches its limit (8000 system clock cycles by default) before a change arrives, the monitor declares the backup oscillator dead.

A failure does not switch the clock source. It only alerts the processor:

- A one-cycle exception request goes out.
- A failed flag is set and stays set until reset.
- An inhibit output is raised. Once the backup oscillator is gone, detection of a primary oscillator failure can no longer be trusted, so the companion primary detector must be switched off.

Software should clear the enable when the backup oscillator is the system clock or has been turned off on purpose. While the enable is clear, the counter stays at zero and no failure can be declared.

The time to detect a failure scales with the system clock period, because the timeout is a cycle count rather than a fixed time.

Top module: `bkosc_loss_monitor`

## Requirements
- R1: The backup clock input passes through a two-stage synchronizer and a change detector. Any level change of the input, rising or falling, resets the cycle counter to zero on the third rising system clock edge after the input changed.
- R2: With the enable set and no backup clock change, `failed_o` rises on exactly the TIMEOUT_CYCLES-th rising edge counted from the first edge that samples the enable high or that follows a counter reset. TIMEOUT_CYCLES defaults to 8000.
- R3: `exc_req_o` is high for exactly one system clock cycle, the cycle in which `failed_o` first becomes 1. It is never high at any other time.
- R4: While `det_en_i` is 0, the counter is held at zero and no failure is declared. After the enable returns to 1, timing starts again from zero.
- R5: `pri_det_inhibit_o` is 1 whenever a failure has been declared and 0 otherwise.
- R6: `failed_o` and `pri_det_inhibit_o` stay at 1 until `rst_ni` is asserted, whatever the backup clock or the enable do. After that first failure no further exception request is produced.
- R7: Backup clock changes spaced at most TIMEOUT_CYCLES system clock cycles apart never cause a failure. Changes spaced TIMEOUT_CYCLES+1 or more cycles apart cause exactly one failure.
- R8: While `rst_ni` is 0, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bk_clk_i | input | 1 | Backup oscillator clock, asynchronous to clk_i |
| det_en_i | input | 1 | Detector enable |
| exc_req_o | output | 1 | One-cycle system exception request on failure |
| failed_o | output | 1 | Sticky backup oscillator failed flag |
| pri_det_inhibit_o | output | 1 | Disables the primary oscillator failure detector |

## Verification
Some rules are checked on every cycle by the embedded assertions:

- The counter never goes past its limit.
- The counter is zero after any cycle in which the enable was low.
- The failed flag, once set, stays set.
- The exception request lasts one cycle and comes only with a new failure.
- No request appears unless the enable was set.

Other behaviour can only be shown by the bench's scenarios. This includes the exact cycle on which a failure is declared, the three-edge latency from a backup clock change to the counter reload, and the boundary between surviving and failing as the spacing of backup clock changes sweeps across TIMEOUT_CYCLES. The bench also shows that dropping the enable mid-count restarts the timing.

// File: rtl/bkosc_pkg.sv
package bkosc_pkg;

  // Width of a counter that must hold values 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bkosc_edge_sync.sv
module bkosc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic change_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign change_o = sync_q[STAGES-1] ^ prev_q;

  // R1: a reported change means the synchronized level moved on the last edge
  sync_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |-> (sync_q[STAGES-1] != $past(sync_q[STAGES-1])));

endmodule

// File: rtl/bkosc_timeout_ctr.sv
module bkosc_timeout_ctr
  import bkosc_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic reload_i,
  input  logic halt_i,
  output logic expire_o
);

  localparam int unsigned CNT_W = cnt_width(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    expire_o = en_i && !reload_i && !halt_i && (cnt_q == LAST_CNT);
    cnt_ce   = 1'b1;
    cnt_d    = cnt_q;
    if (!en_i || reload_i) begin
      cnt_d = '0;
    end else if (halt_i || expire_o) begin
      cnt_ce = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_CNT);

  // R4
  cnt_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

  // R1
  cnt_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt_q == '0));

endmodule

// File: rtl/bkosc_fault_latch.sv
module bkosc_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  output logic failed_o,
  output logic exc_o
);

  logic failed_q, failed_d;
  logic exc_q, exc_d;

  always_comb begin
    failed_d = failed_q | expire_i;
    exc_d    = expire_i & ~failed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      failed_q <= 1'b0;
      exc_q    <= 1'b0;
    end else begin
      failed_q <= failed_d;
      exc_q    <= exc_d;
    end
  end

  assign failed_o = failed_q;
  assign exc_o    = exc_q;

  // R6
  failed_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failed_q |=> failed_q);

  // R3
  exc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_q |=> !exc_q);

  // R3
  exc_with_new_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_q |-> (failed_q && !$past(failed_q)));

endmodule

// File: rtl/bkosc_loss_monitor.sv
module bkosc_loss_monitor #(
  parameter int unsigned TIMEOUT_CYCLES = 8000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bk_clk_i,
  input  logic det_en_i,
  output logic exc_req_o,
  output logic failed_o,
  output logic pri_det_inhibit_o
);

  logic bk_change;
  logic expire;
  logic failed;

  bkosc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_i  (bk_clk_i),
    .change_o (bk_change)
  );

  bkosc_timeout_ctr #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (det_en_i),
    .reload_i (bk_change),
    .halt_i   (failed),
    .expire_o (expire)
  );

  bkosc_fault_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .failed_o (failed),
    .exc_o    (exc_req_o)
  );

  assign failed_o          = failed;
  assign pri_det_inhibit_o = failed;

  // R4
  no_exc_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |=> !exc_req_o);

  // R5
  inhibit_follows_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_req_o) |-> pri_det_inhibit_o);

endmodule

// File: tb/sim_bkosc_loss_monitor.sv
module sim_bkosc_loss_monitor;

  localparam int T = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bk = 1'b0;
  logic en = 1'b0;
  wire  exc, failed, inhibit;

  int n_cmp = 0;
  int n_bad = 0;
  int exc_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bkosc_loss_monitor #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bk_clk_i(bk), .det_en_i(en),
    .exc_req_o(exc), .failed_o(failed), .pri_det_inhibit_o(inhibit)
  );

  always @(negedge clk) if (exc) exc_seen++;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; bk = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    exc_seen = 0;
  endtask

  initial begin
    @(negedge clk);
    step(1);
    // R8 outputs low during reset
    chk("R8 exc", exc, 0); chk("R8 failed", failed, 0); chk("R8 inhibit", inhibit, 0);
    do_reset();

    // R2 exact timeout with static backup clock, R3 pulse, R5 inhibit
    en = 1'b1;
    step(T - 1);
    chk("R2 before limit", failed, 0);
    step(1);
    chk("R2 at limit", failed, 1);
    chk("R3 pulse", exc, 1);
    chk("R5 inhibit", inhibit, 1);
    step(1);
    chk("R3 pulse ends", exc, 0);

    // R6 sticky across toggles and disable
    bk = 1'b1; step(3); bk = 1'b0; en = 1'b0; step(2 * T);
    chk("R6 failed sticky", failed, 1);
    chk("R6 inhibit sticky", inhibit, 1);
    en = 1'b1; step(2 * T);
    chk("R6 single request", exc_seen, 1);
    do_reset();
    chk("R6 cleared by reset", failed, 0);

    // R4 disabled: never fails
    step(3 * T);
    chk("R4 no fail when off", failed, 0);
    chk("R4 no request when off", exc_seen, 0);

    // R4 drop enable mid-count restarts timing
    en = 1'b1; step(T - 2);
    en = 1'b0; step(1);
    en = 1'b1; step(T - 1);
    chk("R4 restart before limit", failed, 0);
    step(1);
    chk("R4 restart at limit", failed, 1);
    do_reset();

    // R1 reload latency: change reloads on third edge
    en = 1'b1; step(5);
    bk = 1'b1;
    step(T + 2);
    chk("R1 reload before limit", failed, 0);
    step(1);
    chk("R1 reload at limit", failed, 1);
    do_reset();

    // R1 falling change also reloads
    bk = 1'b1; step(4);
    en = 1'b1; step(5);
    bk = 1'b0;
    step(T + 2);
    chk("R1 falling reload before limit", failed, 0);
    step(1);
    chk("R1 falling reload at limit", failed, 1);
    do_reset();

    // R7 sweep of change spacing across the boundary
    for (int h = 1; h <= T + 3; h++) begin
      do_reset();
      en = 1'b1;
      for (int i = 0; i < 4 * T; i++) begin
        if (i % h == 0) bk = ~bk;
        step(1);
      end
      chk($sformatf("R7 failed spacing %0d", h), failed, (h > T) ? 1 : 0);
      chk($sformatf("R7 requests spacing %0d", h), exc_seen, (h > T) ? 1 : 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule